// File: doc/BRIEF.md
# Command Ring Free-Space Tracker with Stall Watchdog

This block watches a circular command ring. A consumer moves a head pointer forward and a producer moves a tail pointer forward. The block turns the two pointers and the ring size into a free-byte count. It keeps an 8-byte guard gap between tail and head, so a full ring can never look the same as an empty one. The count and a ring-empty flag are driven combinationally at all times.

A producer that needs room pulses `start_i` with a byte count. It can instead raise `drain_i` with the strobe, which asks for a full drain: the whole ring minus the guard gap. While the request is pending, the block checks the free space once per microsecond tick. It pulses `ready_o` as soon as the space is large enough.

A watchdog limits how many ticks may pass without success. Each time the head is seen to move, the watchdog starts counting again. As a result, `timeout_o` pulses only when the consumer has truly stopped for the full window, not merely because the wait was long.

Top module: `ring_space_watch`

## Requirements
- R1: The head input is reduced to its address field before use. The address field is bits [PTR_W-1:ADDR_LSB], which is bits [15:2] by default. Bits below ADDR_LSB and bits at or above PTR_W have no effect on any output.
- R2: `space_o` equals head − (tail + GUARD), with GUARD = 8. If that result is negative, the ring size is added once. The result is a signed value and can stay negative when tail sits less than GUARD bytes behind head.
- R3: `empty_o` is 1 exactly when the masked head equals the masked tail. In that case `space_o` equals ring size − 8.
- R4: A pending request is checked only on a cycle with `tick_i` = 1. If the check finds `space_o` ≥ the needed count, `ready_o` is 1 for exactly one cycle, in the cycle after that tick, and the request ends.
- R5: When `drain_i` = 0 at the start strobe, the needed count is `req_bytes_i`. When `drain_i` = 1, the needed count is ring size − 8 and `req_bytes_i` is ignored.
- R6: If the head does not move, the request fails after POLL_LIMIT failed checks. `timeout_o` is 1 for exactly one cycle, in the cycle after the last failed check, and the request ends.
- R7: When a failed check sees a head different from the head seen at the previous check (or at the start strobe), that check counts as the first in a new window. Exactly POLL_LIMIT−1 further failed checks are then needed for a timeout.
- R8: A start strobe while a request is pending is ignored. The needed count of the pending request is kept.
- R9: `ready_o` and `timeout_o` are never 1 together. They are never 1 unless a request was pending in the cycle before.
- R10: After reset, no request is pending and `ready_o` = `timeout_o` = 0.
- R11: Cycles without `tick_i` do not check a pending request, even when enough space is available.
- R12: The tail is masked with ring size − 1 before use. The ring size is a power of two no larger than 2^PTR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_raw_i | input | HEAD_W | Consumer head pointer, raw value holding the address field |
| tail_i | input | PTR_W | Producer tail byte offset |
| ring_size_i | input | PTR_W+1 | Ring size in bytes, a power of two |
| req_bytes_i | input | PTR_W+1 | Requested free bytes, taken at the start strobe |
| drain_i | input | 1 | At the start strobe: request a full drain instead of `req_bytes_i` |
| start_i | input | 1 | Start a space request (ignored while one is pending) |
| tick_i | input | 1 | One-microsecond check strobe |
| space_o | output | PTR_W+2 | Signed free-byte count |
| empty_o | output | 1 | Masked head equals masked tail |
| ready_o | output | 1 | One-cycle pulse: request satisfied |
| timeout_o | output | 1 | One-cycle pulse: consumer stalled for the full window |

## Verification
The bench first targets the wrap arithmetic. It covers a head behind the tail and a tail just behind the head, where the result stays negative. A design that dropped the size correction, or added it twice, would report a space that is off by the ring size.

It checks the ≥ comparison at exactly the needed count. A strict comparison would make that request hang. It also checks that drain mode ignores a zero byte request; a design that took the request field would complete that request at once.

The watchdog is checked by counting failed ticks up to the exact timeout cycle, both with a fixed head and after a head movement partway through. An off-by-one window, or a counter that fails to restart, would fire one tick early or late. Finally, a second start strobe during a pending wait, and cycles with ample space but no tick, must leave the request untouched.

// File: rtl/ring_watch_pkg.sv
package ring_watch_pkg;

  typedef enum logic [0:0] {
    REQ_IDLE = 1'b0,
    REQ_WAIT = 1'b1
  } req_state_e;

endpackage

// File: rtl/ring_space_calc.sv
module ring_space_calc #(
  parameter int HEAD_W   = 32,
  parameter int PTR_W    = 16,
  parameter int ADDR_LSB = 2,
  parameter int GUARD    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HEAD_W-1:0]       head_raw,
  input  logic [PTR_W-1:0]        tail_raw,
  input  logic [PTR_W:0]          ring_size,
  output logic [PTR_W-1:0]        head_m,
  output logic signed [PTR_W+1:0] space,
  output logic                    empty
);
  localparam int SW = PTR_W + 2;
  localparam logic [PTR_W-1:0] LOW_MASK   = PTR_W'((1 << ADDR_LSB) - 1);
  localparam logic [PTR_W-1:0] FIELD_MASK = ~LOW_MASK;

  logic [PTR_W-1:0] tail_m;

  // keep only the address field of the head
  function automatic logic [PTR_W-1:0] addr_field(input logic [PTR_W-1:0] low_bits);
    return low_bits & FIELD_MASK;
  endfunction

  // signed free bytes with guard gap and one size correction
  function automatic logic signed [SW-1:0] free_bytes(
    input logic [PTR_W-1:0] h,
    input logic [PTR_W-1:0] t,
    input logic [PTR_W:0]   s
  );
    logic signed [SW-1:0] d;
    d = $signed({2'b00, h}) - $signed({2'b00, t}) - $signed(SW'(GUARD));
    if (d < 0) d = d + $signed({1'b0, s});
    return d;
  endfunction

  generate
    if (HEAD_W > PTR_W) begin : g_upper
      logic unused_head_upper;
      assign unused_head_upper = ^head_raw[HEAD_W-1:PTR_W];
    end
  endgenerate

  assign head_m = addr_field(head_raw[PTR_W-1:0]);
  assign tail_m = tail_raw & PTR_W'(ring_size - 1'b1);
  assign space  = free_bytes(head_m, tail_m, ring_size);
  assign empty  = (head_m == tail_m);

  // R3: an empty ring reports the whole ring minus the guard gap
  assert_empty_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (space == ($signed({1'b0, ring_size}) - $signed(SW'(GUARD)))));

  // R12: masked tail always lies inside the ring
  assert_tail_inside_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, tail_m} < ring_size));

  // R1: the head used is always aligned to the address field
  assert_head_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((head_m & LOW_MASK) == '0));

endmodule

// File: rtl/ring_stall_timer.sv
module ring_stall_timer #(
  parameter int PTR_W      = 16,
  parameter int POLL_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             poll_miss,
  input  logic [PTR_W-1:0] head_m,
  output logic             moved,
  output logic             expire
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(POLL_LIMIT);

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    next_cnt;
  logic [PTR_W-1:0] last_head;

  assign moved    = (head_m != last_head);
  assign next_cnt = moved ? CW'(1) : cnt + 1'b1;
  assign expire   = poll_miss && (next_cnt >= LIMIT_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      last_head <= '0;
    end else if (arm) begin
      cnt       <= '0;
      last_head <= head_m;
    end else if (poll_miss) begin
      cnt       <= next_cnt;
      last_head <= head_m;
    end
  end

  // R6: the window counter never runs past its limit
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT_C);

  // R7: a failed check that sees head movement opens a fresh window
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_miss && moved && !arm) |=> (cnt == CW'(1)));

  // R6: arming clears the window
  assert_arm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cnt == '0));

endmodule

// File: rtl/ring_req_ctrl.sv
module ring_req_ctrl
  import ring_watch_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int GUARD = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    drain,
  input  logic [PTR_W:0]          req_bytes,
  input  logic [PTR_W:0]          ring_size,
  input  logic                    tick,
  input  logic signed [PTR_W+1:0] space,
  input  logic                    expire,
  output logic                    arm,
  output logic                    poll_miss,
  output logic                    ready_q,
  output logic                    timeout_q
);
  req_state_e     state;
  logic [PTR_W:0] need;
  logic           enough;
  logic           polling;

  assign enough    = space >= $signed({1'b0, need});
  assign polling   = (state == REQ_WAIT) && tick;
  assign arm       = (state == REQ_IDLE) && start;
  assign poll_miss = polling && !enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= REQ_IDLE;
      need      <= '0;
      ready_q   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      ready_q   <= 1'b0;
      timeout_q <= 1'b0;
      if (arm) begin
        need  <= drain ? (ring_size - (PTR_W+1)'(GUARD)) : req_bytes;
        state <= REQ_WAIT;
      end else if (polling) begin
        if (enough) begin
          ready_q <= 1'b1;
          state   <= REQ_IDLE;
        end else if (expire) begin
          timeout_q <= 1'b1;
          state     <= REQ_IDLE;
        end
      end
    end
  end

  // R4: ready lasts one cycle
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);

  // R6: timeout lasts one cycle
  assert_timeout_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |=> !timeout_q);

  // R9: outcomes are exclusive
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_q && timeout_q));

  // R9: an outcome needs a pending request one cycle earlier
  assert_outcome_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q || timeout_q) |-> ($past(state) == REQ_WAIT));

  // R8: a strobe during a pending wait leaves the need untouched
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == REQ_WAIT && start) |=> $stable(need));

  // R5: drain mode asks for ring size minus the guard gap
  assert_drain_need_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && drain) |=> (need == $past(ring_size) - (PTR_W+1)'(GUARD)));

  // R11: no tick, no outcome
  assert_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == REQ_WAIT && !tick) |=> !(ready_q || timeout_q));

endmodule

// File: rtl/ring_space_watch.sv
module ring_space_watch #(
  parameter int HEAD_W     = 32,
  parameter int PTR_W      = 16,
  parameter int ADDR_LSB   = 2,
  parameter int GUARD      = 8,
  parameter int POLL_LIMIT = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HEAD_W-1:0]       head_raw_i,
  input  logic [PTR_W-1:0]        tail_i,
  input  logic [PTR_W:0]          ring_size_i,
  input  logic [PTR_W:0]          req_bytes_i,
  input  logic                    drain_i,
  input  logic                    start_i,
  input  logic                    tick_i,
  output logic signed [PTR_W+1:0] space_o,
  output logic                    empty_o,
  output logic                    ready_o,
  output logic                    timeout_o
);
  logic [PTR_W-1:0]        head_m;
  logic signed [PTR_W+1:0] space_w;
  logic                    arm_w;
  logic                    poll_miss_w;
  logic                    moved_w;
  logic                    expire_w;

  ring_space_calc #(
    .HEAD_W(HEAD_W), .PTR_W(PTR_W), .ADDR_LSB(ADDR_LSB), .GUARD(GUARD)
  ) u_calc (
    .clk(clk), .rst_n(rst_n),
    .head_raw(head_raw_i), .tail_raw(tail_i), .ring_size(ring_size_i),
    .head_m(head_m), .space(space_w), .empty(empty_o)
  );

  ring_stall_timer #(
    .PTR_W(PTR_W), .POLL_LIMIT(POLL_LIMIT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .arm(arm_w), .poll_miss(poll_miss_w), .head_m(head_m),
    .moved(moved_w), .expire(expire_w)
  );

  ring_req_ctrl #(
    .PTR_W(PTR_W), .GUARD(GUARD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start_i), .drain(drain_i), .req_bytes(req_bytes_i),
    .ring_size(ring_size_i), .tick(tick_i), .space(space_w),
    .expire(expire_w), .arm(arm_w), .poll_miss(poll_miss_w),
    .ready_q(ready_o), .timeout_q(timeout_o)
  );

  assign space_o = space_w;

  // R7: expiry is never declared on a check that saw the head move, unless the window is one check long
  assert_no_expire_on_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && moved_w) |-> (POLL_LIMIT <= 1));

endmodule

// File: tb/sim_ring_space_watch.sv
`timescale 1ns/1ps
module sim_ring_space_watch;
  localparam int HEAD_W = 32;
  localparam int PTR_W  = 16;
  localparam int LIMIT  = 20;
  localparam int SIZE   = 1024;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [HEAD_W-1:0]       head_raw_i = '0;
  logic [PTR_W-1:0]        tail_i = '0;
  logic [PTR_W:0]          ring_size_i = (PTR_W+1)'(SIZE);
  logic [PTR_W:0]          req_bytes_i = '0;
  logic                    drain_i = 1'b0;
  logic                    start_i = 1'b0;
  logic                    tick_i = 1'b0;
  logic signed [PTR_W+1:0] space_o;
  logic                    empty_o;
  logic                    ready_o;
  logic                    timeout_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_space_watch #(.HEAD_W(HEAD_W), .PTR_W(PTR_W), .ADDR_LSB(2),
                     .GUARD(8), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .head_raw_i(head_raw_i), .tail_i(tail_i),
    .ring_size_i(ring_size_i), .req_bytes_i(req_bytes_i), .drain_i(drain_i),
    .start_i(start_i), .tick_i(tick_i), .space_o(space_o), .empty_o(empty_o),
    .ready_o(ready_o), .timeout_o(timeout_o));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_space(input int h, input int t);
    int d;
    d = h - t - 8;
    if (d < 0) d += SIZE;
    return d;
  endfunction

  task automatic set_ptrs(input int h, input int t);
    @(negedge clk);
    head_raw_i = HEAD_W'(h);
    tail_i = PTR_W'(t);
    #1;
  endtask

  task automatic begin_req(input int bytes, input bit drain);
    @(negedge clk);
    req_bytes_i = (PTR_W+1)'(bytes);
    drain_i = drain;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain_i = 1'b0;
  endtask

  // one check strobe; returns outcome visible after the deciding edge
  task automatic poll(output bit rdy, output bit tmo);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    rdy = ready_o;
    tmo = timeout_o;
  endtask

  task automatic t_reset;
    chk("R10 ready after reset", int'(ready_o), 0);
    chk("R10 timeout after reset", int'(timeout_o), 0);
    chk("R3 empty at reset pointers", int'(empty_o), 1);
    chk("R3 space when empty", int'(space_o), SIZE - 8);
  endtask

  task automatic t_space;
    set_ptrs(32'h100, 16'h040);
    chk("R2 head ahead", int'(space_o), model_space(32'h100, 32'h040));
    set_ptrs(32'h040, 16'h100);
    chk("R2 wrap", int'(space_o), model_space(32'h040, 32'h100));
    set_ptrs(32'h000, 16'h3FC);
    chk("R2 stays negative", int'(space_o), -4);
    set_ptrs(32'hABCD_0103, 16'h040);
    chk("R1 head masked", int'(space_o), model_space(32'h100, 32'h040));
    set_ptrs(32'h100, 16'h440);
    chk("R12 tail masked", int'(space_o), model_space(32'h100, 32'h040));
    set_ptrs(32'h203, 16'h200);
    chk("R3 R1 empty with low bits", int'(empty_o), 1);
    set_ptrs(32'h204, 16'h200);
    chk("R3 not empty", int'(empty_o), 0);
  endtask

  task automatic t_ready_tick;
    bit r, t;
    set_ptrs(32'h100, 16'h040);  // space 184
    begin_req(100, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 no check without tick", int'(ready_o), 0);
    end
    poll(r, t);
    chk("R4 ready on tick", int'(r), 1);
    chk("R9 no timeout with ready", int'(t), 0);
    @(negedge clk);
    chk("R4 ready one cycle", int'(ready_o), 0);
  endtask

  task automatic t_boundary;
    bit r, t;
    set_ptrs(32'h100, 16'h040);
    begin_req(184, 1'b0);
    poll(r, t);
    chk("R4 exact need ready", int'(r), 1);
    begin_req(185, 1'b0);
    poll(r, t);
    chk("R4 one short not ready", int'(r), 0);
    set_ptrs(32'h104, 16'h040);  // 188
    poll(r, t);
    chk("R4 ready after head move", int'(r), 1);
  endtask

  task automatic t_drain;
    bit r, t;
    set_ptrs(32'h080, 16'h080);
    begin_req(0, 1'b1);
    poll(r, t);
    chk("R5 drain ready when empty", int'(r), 1);
    set_ptrs(32'h080, 16'h100);  // 888 < 1016
    begin_req(0, 1'b1);
    poll(r, t);
    chk("R5 drain ignores zero request", int'(r), 0);
    for (int i = 1; i < LIMIT - 1; i++) poll(r, t);
    poll(r, t);
    chk("R6 drain times out", int'(t), 1);
  endtask

  task automatic t_timeout;
    bit r, t;
    int early;
    early = 0;
    set_ptrs(32'h080, 16'h100);
    begin_req(1000, 1'b0);
    for (int i = 0; i < LIMIT - 1; i++) begin
      poll(r, t);
      if (r || t) early++;
    end
    chk("R6 no early outcome", early, 0);
    poll(r, t);
    chk("R6 timeout at limit", int'(t), 1);
    chk("R9 no ready with timeout", int'(r), 0);
    @(negedge clk);
    chk("R6 timeout one cycle", int'(timeout_o), 0);
  endtask

  task automatic t_restart;
    bit r, t;
    int early;
    early = 0;
    set_ptrs(32'h080, 16'h100);
    begin_req(1000, 1'b0);
    for (int i = 0; i < 5; i++) poll(r, t);
    set_ptrs(32'h090, 16'h100);  // 904, still short
    poll(r, t);
    if (r || t) early++;
    for (int i = 0; i < LIMIT - 2; i++) begin
      poll(r, t);
      if (r || t) early++;
    end
    chk("R7 window restarted", early, 0);
    poll(r, t);
    chk("R7 timeout after new window", int'(t), 1);
  endtask

  task automatic t_busy_start;
    bit r, t;
    set_ptrs(32'h100, 16'h040);  // 184
    begin_req(1000, 1'b0);
    begin_req(10, 1'b0);
    poll(r, t);
    chk("R8 second start ignored", int'(r), 0);
    set_ptrs(32'h040, 16'h040);  // 1016
    poll(r, t);
    chk("R8 original need served", int'(r), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_space();
    t_ready_tick();
    t_boundary();
    t_drain();
    t_timeout();
    t_restart();
    t_busy_start();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule